// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a four-beat burst into a synchronous memory. When either of two address strobes is high at a rising clock edge, it captures a starting address and an ordering choice. The captured upper address bits then pass to the output unchanged. The two lowest address bits come from an internal beat counter. That counter steps once for each clock edge at which the advance input is high, and it wraps after the fourth beat.

Two orderings are supported. In linear order the low field counts upward from its starting value and wraps within four addresses. In interleaved order the low field is the starting low field XOR the beat number. The ordering input is sampled only when a strobe loads the block, so a burst keeps its order from start to end. A parameter can fix the ordering at elaboration time; when it does, the runtime selector is dropped from the logic.

The block drives the full current address and the beat position. Chip enables, data paths and the storage array belong to the surrounding logic.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr_out` and `beat` are zero. After reset is released, an advance with no strobe steps away from address zero (`beat` 1 gives `addr_out` 1).
- R2: When `strobe_a` or `strobe_b` (or both) is high at a rising edge, that edge loads `addr_in` and `il_sel`. After that edge `addr_out` equals the loaded address and `beat` is 0.
- R3: When no strobe is high and `adv` is high at an edge, `beat` increases by one modulo 4.
- R4: When no strobe and no `adv` are high at an edge, `beat` and `addr_out` keep their values.
- R5: With linear order loaded (`il_sel`=0), `addr_out[1:0]` equals (start low bits + `beat`) mod 4. A start of 2 gives the sequence 2, 3, 0, 1.
- R6: With interleaved order loaded (`il_sel`=1), `addr_out[1:0]` equals the start low bits XOR `beat`.
- R7: `addr_out[ADDR_W-1:2]` stays equal to the loaded upper bits until the next load. `addr_in` has no effect at an edge where no strobe is high.
- R8: An advance at `beat` 3 returns `beat` to 0, so `addr_out` becomes the starting address again.
- R9: A strobe at the same edge as `adv` reloads the block; the advance is ignored.
- R10: A change of `il_sel` between loads has no effect on the ordering of the current burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_a | input | 1 | First address strobe; loads start address and order |
| strobe_b | input | 1 | Second address strobe; same effect as strobe_a |
| adv | input | 1 | Advance to the next beat |
| il_sel | input | 1 | Order choice sampled at load: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | Starting address |
| addr_out | output | ADDR_W | Current burst address |
| beat | output | CNT_W | Position within the burst |

## Verification
The bench builds the block with a 12-bit address, the 2-bit beat field and runtime order selection. This keeps both orderings, and switching between them from one burst to the next, reachable in a single build. The narrow address lets the vectors put distinct patterns in the upper field, so an upper bit that leaks or is reloaded without a strobe shows up. Every start offset from 0 to 3 appears in at least one burst, together with wraparound, strobe-over-advance priority, a mode change in mid-burst and a reset in mid-burst.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
   // Ordering variants selectable at elaboration time
   localparam int ORDER_RUNTIME     = 0;
   localparam int ORDER_LINEAR      = 1;
   localparam int ORDER_INTERLEAVED = 2;

   typedef enum logic {
      BURST_LINEAR      = 1'b0,
      BURST_INTERLEAVED = 1'b1
   } burst_order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
   parameter int ADDR_W = 20
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             load,
   input  logic [ADDR_W-1:0]                addr_in,
   input  burst_addr_pkg::burst_order_e     order_in,
   output logic [ADDR_W-1:0]                base_q,
   output burst_addr_pkg::burst_order_e     order_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         order_q <= burst_addr_pkg::BURST_LINEAR;
      end else if (load) begin
         base_q  <= addr_in;
         order_q <= order_in;
      end
   end

   // R10: the captured order changes only on a load
   a_r10_order_held: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(order_q));
   // R7: the start address is ignored without a load
   a_r7_base_held: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(base_q));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             adv,
   output logic [CNT_W-1:0] beat_q
);
   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);
   localparam logic [CNT_W-1:0] LAST = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         beat_q <= '0;
      else if (load)
         beat_q <= '0;
      else if (adv)
         beat_q <= beat_q + STEP;
   end

   // R2 / R9: a load restarts the burst, even with adv high
   a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (beat_q == '0));
   // R3: one step per advance
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && adv && beat_q != LAST) |=> (beat_q == $past(beat_q) + STEP));
   // R8: wrap after the last beat
   a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && adv && beat_q == LAST) |=> (beat_q == '0));
   // R4: idle holds
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(beat_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
   parameter int CNT_W     = 2,
   parameter int ORDER_SEL = 0
) (
   input  logic [CNT_W-1:0]              start_low,
   input  logic [CNT_W-1:0]              beat,
   input  burst_addr_pkg::burst_order_e  order,
   output logic [CNT_W-1:0]              low_out
);
   import burst_addr_pkg::*;

   logic [CNT_W-1:0] lin_low;
   logic [CNT_W-1:0] il_low;

   always_comb begin
      lin_low = start_low + beat;   // wraps modulo 2**CNT_W
      il_low  = start_low ^ beat;
   end

   generate
      if (ORDER_SEL == ORDER_LINEAR) begin : g_lin
         assign low_out = lin_low;
      end else if (ORDER_SEL == ORDER_INTERLEAVED) begin : g_il
         assign low_out = il_low;
      end else if (ORDER_SEL == ORDER_RUNTIME) begin : g_rt
         assign low_out = (order == BURST_INTERLEAVED) ? il_low : lin_low;
      end else begin : g_bad
         assign low_out = '0;
         $error("burst_order_map: ORDER_SEL must be 0, 1 or 2");
      end
   endgenerate
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
   parameter int ADDR_W    = 20,
   parameter int CNT_W     = 2,
   parameter int ORDER_SEL = burst_addr_pkg::ORDER_RUNTIME
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_a,
   input  logic              strobe_b,
   input  logic              adv,
   input  logic              il_sel,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out,
   output logic [CNT_W-1:0]  beat
);
   import burst_addr_pkg::*;

   localparam int UP_W = ADDR_W - CNT_W;

   generate
      if (CNT_W < 1)       begin : g_chk_cnt  $error("CNT_W must be at least 1"); end
      if (UP_W < 1)        begin : g_chk_addr $error("ADDR_W must exceed CNT_W"); end
      if (ORDER_SEL < 0 || ORDER_SEL > 2)
                           begin : g_chk_ord  $error("ORDER_SEL out of range"); end
   endgenerate

   logic              load;
   logic [ADDR_W-1:0] base_q;
   burst_order_e      order_q;
   burst_order_e      order_in;
   logic [CNT_W-1:0]  beat_q;
   logic [CNT_W-1:0]  low_bits;

   assign load     = strobe_a | strobe_b;
   assign order_in = il_sel ? BURST_INTERLEAVED : BURST_LINEAR;

   burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
      .clk(clk), .rst_n(rst_n), .load(load), .addr_in(addr_in),
      .order_in(order_in), .base_q(base_q), .order_q(order_q)
   );

   burst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .beat_q(beat_q)
   );

   burst_order_map #(.CNT_W(CNT_W), .ORDER_SEL(ORDER_SEL)) u_map (
      .start_low(base_q[CNT_W-1:0]), .beat(beat_q), .order(order_q),
      .low_out(low_bits)
   );

   assign addr_out = {base_q[ADDR_W-1:CNT_W], low_bits};
   assign beat     = beat_q;

   // R2: a load presents the strobed address on the next cycle
   a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (addr_out == $past(addr_in) && beat == '0));
   // R7: upper field fixed between loads
   a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(addr_out[ADDR_W-1:CNT_W]));
   // R8: beat zero always shows the starting address
   a_r8_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (beat == '0) |-> (addr_out == base_q));
   // R4: no strobe and no advance leaves the address unchanged
   a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(addr_out));
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
   localparam int AW = 12;
   localparam int CW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strobe_a = 1'b0, strobe_b = 1'b0, adv = 1'b0, il_sel = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;
   logic [CW-1:0] beat;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   burst_addr_gen #(.ADDR_W(AW), .CNT_W(CW), .ORDER_SEL(0)) dut (
      .clk(clk), .rst_n(rst_n), .strobe_a(strobe_a), .strobe_b(strobe_b),
      .adv(adv), .il_sel(il_sel), .addr_in(addr_in),
      .addr_out(addr_out), .beat(beat)
   );

   typedef struct packed {
      logic          sa;
      logic          sb;
      logic          adv;
      logic          il;
      logic [AW-1:0] a_in;
      logic [AW-1:0] e_addr;
      logic [CW-1:0] e_beat;
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0,1'b0,1'b0,12'hA5E,12'hA5E,2'd0,4'd2},  // R2 load, linear, start 2
      '{1'b0,1'b0,1'b1,1'b0,12'h000,12'hA5F,2'd1,4'd5},  // R5 2->3
      '{1'b0,1'b0,1'b1,1'b0,12'h000,12'hA5C,2'd2,4'd5},  // R5 3->0
      '{1'b0,1'b0,1'b1,1'b0,12'h000,12'hA5D,2'd3,4'd5},  // R5 0->1
      '{1'b0,1'b0,1'b1,1'b0,12'h000,12'hA5E,2'd0,4'd8},  // R8 wrap to start
      '{1'b0,1'b0,1'b0,1'b0,12'h000,12'hA5E,2'd0,4'd4},  // R4 idle
      '{1'b0,1'b1,1'b0,1'b1,12'h3C1,12'h3C1,2'd0,4'd2},  // R2 second strobe, il
      '{1'b0,1'b0,1'b1,1'b1,12'h000,12'h3C0,2'd1,4'd6},  // R6 1^1
      '{1'b0,1'b0,1'b1,1'b1,12'h000,12'h3C3,2'd2,4'd6},  // R6 1^2
      '{1'b0,1'b0,1'b0,1'b1,12'hFFF,12'h3C3,2'd2,4'd4},  // R4 idle, addr_in ignored
      '{1'b0,1'b0,1'b1,1'b1,12'h000,12'h3C2,2'd3,4'd6},  // R6 1^3
      '{1'b0,1'b0,1'b1,1'b1,12'h000,12'h3C1,2'd0,4'd8},  // R8 wrap
      '{1'b0,1'b0,1'b1,1'b0,12'hFFF,12'h3C0,2'd1,4'd10}, // R10 il_sel change ignored; R7
      '{1'b1,1'b0,1'b1,1'b1,12'h7F3,12'h7F3,2'd0,4'd9},  // R9 strobe beats adv
      '{1'b0,1'b0,1'b1,1'b1,12'h000,12'h7F2,2'd1,4'd6},  // R6 3^1
      '{1'b0,1'b0,1'b1,1'b1,12'h000,12'h7F1,2'd2,4'd6},  // R6 3^2
      '{1'b1,1'b1,1'b0,1'b0,12'h004,12'h004,2'd0,4'd2},  // R2 both strobes
      '{1'b0,1'b0,1'b1,1'b0,12'h000,12'h005,2'd1,4'd3}   // R3 step from 0
   };

   task automatic check(input string tag, input logic [AW-1:0] ea, input logic [CW-1:0] eb);
      n_checks++;
      if (addr_out !== ea || beat !== eb) begin
         n_fails++;
         $display("FAIL %s: addr_out=%h beat=%0d expected addr_out=%h beat=%0d",
                  tag, addr_out, beat, ea, eb);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset state", '0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      adv = 1'b1;
      @(negedge clk);
      check("R1 advance from reset", 12'h001, 2'd1);

      foreach (VECS[i]) begin
         strobe_a = VECS[i].sa;
         strobe_b = VECS[i].sb;
         adv      = VECS[i].adv;
         il_sel   = VECS[i].il;
         addr_in  = VECS[i].a_in;
         @(negedge clk);
         check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].e_addr, VECS[i].e_beat);
      end

      // R5: linear start 1 covers offset 1 and wrap of the low field
      strobe_a = 1'b1; adv = 1'b0; il_sel = 1'b0; addr_in = 12'h8A9;
      @(negedge clk);
      strobe_a = 1'b0; adv = 1'b1; addr_in = 12'h000;
      @(negedge clk); @(negedge clk); @(negedge clk);
      check("R5 linear start 1 beat 3", 12'h8A8, 2'd3);

      // R1: reset in the middle of a burst
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid-burst", '0, '0);
      adv = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R4 idle after reset", '0, '0);
      finish_run();
   end
endmodule